// File: doc/BRIEF.md
# Comparator-Steered Mismatch Calibration Sequencer

This controller measures the current-source mismatch of a binary-weighted current-steering DAC, using nothing but a one-bit current comparator as feedback. On a start pulse it first finds the error of the dummy source that stands beside the MSB array. It then finds the errors of the MSB sources, one after another from the lowest to the highest. Every source is measured twice, once with the comparator inputs in each orientation (phase A and phase B), so that comparator offset and mirror mismatch drop out of the difference between the two results.

Each measurement is a successive-approximation search. The dummy source is trimmed against the 6-bit subtraction DAC. An MSB source is trimmed against an 11-bit fine code, made of the 8 LSB-array bits above the 3 trim-array bits. While the MSB sources are measured, the subtraction DAC stays at the code that cancels the dummy error found earlier. Each MSB error is built recursively from the errors already stored for the lower sources. The results sit in a register file with a combinational read port, ready for the conversion datapath.

The stored errors leave the block through a plain indexed read port. No stream interface is involved, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `cal_seq_top`

## Requirements
- R1: After reset, busy and done are low, sub_code and fine_code are 0 and all seven stored errors read 0.
- R2: A calibration visits meas_sel 0 (dummy) and then 1 to 6 (MSB source k-1) in ascending order. Each visit runs phase A (phase_b=0) first and phase B (phase_b=1) second, which gives exactly 14 (meas_sel, phase_b) measurement slots.
- R3: Each search tests the bits from the MSB down: the trial bit is set, and it is kept if the synchronized comparator is 1 and cleared if it is 0. A comparator that is 1 exactly when the code is at or below a target therefore yields that target (0..63 on sub_code, 0..2047 on fine_code).
- R4: The comparator is sampled settle_cycles+2 cycles after the trial code changes. The extra two cycles cover the two-flop synchronizer on cmp_async.
- R5: The dummy error is e0 = -floor((A+B-64)/2), where A and B are the phase A and phase B sub_code results read as offset binary about 32.
- R6: For MSB visit k (1..6), the stored value is e_k = (e_1+...+e_(k-1)) - (A_k - B_k). This is twice the source error, as a signed 20-bit word.
- R7: During MSB visits sub_code equals (32 - e0) mod 64. During the dummy visit fine_code is all ones.
- R8: rd_err returns the stored error selected by rd_idx: index 0 is the dummy, index k is MSB visit k.
- R9: done is high for exactly one cycle, in the cycle after the last MSB error is stored, and busy is low in that cycle.
- R10: start is ignored while a calibration is running: it neither restarts the run nor changes any result.
- R11: While not busy, sub_code and fine_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| settle_cycles | input | 4 | Extra analog settling cycles per trial |
| cmp_async | input | 1 | Raw comparator output |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| meas_sel | output | 3 | Source under measurement (0 dummy, k MSB k-1) |
| phase_b | output | 1 | Comparator orientation, 0 = phase A |
| sub_code | output | 6 | Subtraction DAC code |
| fine_code | output | 11 | LSB-array bits above trim-array bits |
| rd_idx | input | 3 | Error read index |
| rd_err | output | 20 | Signed stored error |

## Verification
The bound assertions check on every cycle that done is a one-cycle pulse following busy, that visits never go backwards and always open in phase A, that sub_code stays at the cancelling code during MSB visits, that fine_code is all ones during the dummy visit, and that the codes are idle outside a run. Only the bench scenarios can show that the searches converge to the right codes under a comparator delayed by exactly settle_cycles, that the rounding and the recursive accumulation give the right error words at the code extremes, and that a start during a run changes nothing.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GO,
    ST_RUN,
    ST_CALC,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/cal_sar_engine.sv
module cal_sar_engine #(
  parameter int W  = 6,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          cmp,
  input  logic [CW-1:0] wait_len,
  output logic [W-1:0]  trial,
  output logic          fin
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  mask_q, trial_q, kept;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;

  // keep the bit under test only when the comparator says the code is not too high
  assign kept = cmp ? trial_q : (trial_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      trial_q <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        run_q   <= 1'b1;
        mask_q  <= TOP_BIT;
        trial_q <= TOP_BIT;
        cnt_q   <= '0;
      end else if (run_q) begin
        if (cnt_q == wait_len) begin
          cnt_q <= '0;
          if (mask_q[0]) begin
            run_q   <= 1'b0;
            fin_q   <= 1'b1;
            trial_q <= kept;
          end else begin
            mask_q  <= mask_q >> 1;
            trial_q <= kept | (mask_q >> 1);
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign trial = trial_q;
  assign fin   = fin_q;
endmodule

// File: rtl/cal_err_bank.sv
module cal_err_bank #(
  parameter int N_MSB   = 6,
  parameter int FINE_W  = 11,
  parameter int ERR_W   = 20,
  parameter int SEL_W   = 3,
  parameter int SUB_MID = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr,
  input  logic [SEL_W-1:0]        stage,
  input  logic [FINE_W-1:0]       res_a,
  input  logic [FINE_W-1:0]       res_b,
  input  logic [SEL_W-1:0]        rd_idx,
  output logic signed [ERR_W-1:0] rd_err,
  output logic signed [ERR_W-1:0] dummy_err
);
  localparam logic signed [ERR_W-1:0] MID2 = ERR_W'(2 * SUB_MID);

  logic signed [ERR_W-1:0] err_q [N_MSB+1];
  logic signed [ERR_W-1:0] sum_q;
  logic signed [ERR_W-1:0] a_s, b_s, dummy_val, msb_val;

  assign a_s       = $signed(ERR_W'(res_a));
  assign b_s       = $signed(ERR_W'(res_b));
  assign dummy_val = -((a_s + b_s - MID2) >>> 1);
  assign msb_val   = sum_q - (a_s - b_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 sum_q <= '0;
    else if (clr)                               sum_q <= '0;
    else if (wr && stage != '0)                 sum_q <= sum_q + msb_val;
  end

  for (genvar g = 0; g <= N_MSB; g++) begin : g_entry
    if (g == 0) begin : g_dummy
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             err_q[g] <= '0;
        else if (wr && stage == SEL_W'(g))      err_q[g] <= dummy_val;
      end
    end else begin : g_msb
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             err_q[g] <= '0;
        else if (wr && stage == SEL_W'(g))      err_q[g] <= msb_val;
      end
    end
  end

  always_comb begin
    rd_err = '0;
    for (int i = 0; i <= N_MSB; i++)
      if (rd_idx == SEL_W'(i)) rd_err = err_q[i];
  end

  assign dummy_err = err_q[0];
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top #(
  parameter int SUB_W    = 6,
  parameter int LSB_W    = 8,
  parameter int CAL_W    = 3,
  parameter int N_MSB    = 6,
  parameter int SETTLE_W = 4,
  parameter int ERR_W    = 20,
  parameter int SEL_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [SETTLE_W-1:0]             settle_cycles,
  input  logic                            cmp_async,
  output logic                            busy,
  output logic                            done,
  output logic [SEL_W-1:0]                meas_sel,
  output logic                            phase_b,
  output logic [SUB_W-1:0]                sub_code,
  output logic [LSB_W+CAL_W-1:0]          fine_code,
  input  logic [SEL_W-1:0]                rd_idx,
  output logic signed [ERR_W-1:0]         rd_err
);
  import cal_seq_pkg::*;

  localparam int FINE_W  = LSB_W + CAL_W;
  localparam int WAIT_W  = SETTLE_W + 1;
  localparam int SUB_MID = 1 << (SUB_W - 1);
  localparam int SYNC_N  = 2;

  cal_state_e            state_q;
  logic [SEL_W-1:0]      stage_q;
  logic                  ph_q;
  logic [FINE_W-1:0]     ra_q, rb_q;
  logic                  cmp_s;
  logic [WAIT_W-1:0]     wait_len;
  logic                  sub_go, fine_go, sub_fin, fine_fin, cur_fin;
  logic [SUB_W-1:0]      sub_trial, sub_hold;
  logic [FINE_W-1:0]     fine_trial, cur_res;
  logic                  clr, wr;
  logic signed [ERR_W-1:0] dummy_err, hold_w;

  cal_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_async), .q(cmp_s)
  );

  assign wait_len = WAIT_W'(settle_cycles) + WAIT_W'(SYNC_N);
  assign sub_go   = (state_q == ST_GO) && (stage_q == '0);
  assign fine_go  = (state_q == ST_GO) && (stage_q != '0);

  cal_sar_engine #(.W(SUB_W), .CW(WAIT_W)) u_sub_sar (
    .clk(clk), .rst_n(rst_n), .go(sub_go), .cmp(cmp_s),
    .wait_len(wait_len), .trial(sub_trial), .fin(sub_fin)
  );

  cal_sar_engine #(.W(FINE_W), .CW(WAIT_W)) u_fine_sar (
    .clk(clk), .rst_n(rst_n), .go(fine_go), .cmp(cmp_s),
    .wait_len(wait_len), .trial(fine_trial), .fin(fine_fin)
  );

  assign cur_fin = (stage_q == '0) ? sub_fin : fine_fin;
  assign cur_res = (stage_q == '0) ? FINE_W'(sub_trial) : fine_trial;
  assign clr     = (state_q == ST_IDLE) && start;
  assign wr      = (state_q == ST_CALC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      ph_q    <= 1'b0;
      ra_q    <= '0;
      rb_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          stage_q <= '0;
          ph_q    <= 1'b0;
          state_q <= ST_GO;
        end
        ST_GO:   state_q <= ST_RUN;
        ST_RUN:  if (cur_fin) begin
          if (!ph_q) begin
            ra_q    <= cur_res;
            ph_q    <= 1'b1;
            state_q <= ST_GO;
          end else begin
            rb_q    <= cur_res;
            state_q <= ST_CALC;
          end
        end
        ST_CALC: begin
          if (stage_q == SEL_W'(N_MSB)) begin
            state_q <= ST_DONE;
          end else begin
            stage_q <= stage_q + 1'b1;
            ph_q    <= 1'b0;
            state_q <= ST_GO;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  cal_err_bank #(
    .N_MSB(N_MSB), .FINE_W(FINE_W), .ERR_W(ERR_W),
    .SEL_W(SEL_W), .SUB_MID(SUB_MID)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr), .stage(stage_q),
    .res_a(ra_q), .res_b(rb_q), .rd_idx(rd_idx), .rd_err(rd_err),
    .dummy_err(dummy_err)
  );

  // subtraction DAC parked where it cancels the dummy-source error
  assign hold_w   = ERR_W'(SUB_MID) - dummy_err;
  assign sub_hold = hold_w[SUB_W-1:0];

  assign busy      = (state_q == ST_GO) || (state_q == ST_RUN) || (state_q == ST_CALC);
  assign done      = (state_q == ST_DONE);
  assign meas_sel  = stage_q;
  assign phase_b   = ph_q;
  assign sub_code  = !busy ? '0 : ((stage_q == '0) ? sub_trial : sub_hold);
  assign fine_code = !busy ? '0 : ((stage_q == '0) ? '1 : fine_trial);
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
  parameter int SUB_W  = 6,
  parameter int FINE_W = 11,
  parameter int ERR_W  = 20,
  parameter int SEL_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [SEL_W-1:0]        meas_sel,
  input logic                    phase_b,
  input logic [SUB_W-1:0]        sub_code,
  input logic [FINE_W-1:0]       fine_code,
  input logic signed [ERR_W-1:0] dummy_err
);
  localparam int SUB_MID = 1 << (SUB_W - 1);
  logic signed [ERR_W-1:0] exp_hold;
  assign exp_hold = ERR_W'(SUB_MID) - dummy_err;

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r2_sel_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (meas_sel >= $past(meas_sel)));
  a_r2_visit_opens_a: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (meas_sel != $past(meas_sel))) |-> !phase_b);
  a_r7_sub_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && meas_sel != '0) |-> (sub_code == exp_hold[SUB_W-1:0]));
  a_r7_fine_full: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && meas_sel == '0) |-> (fine_code == '1));
  a_r11_idle_codes: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sub_code == '0 && fine_code == '0));
  a_r10_start_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind cal_seq_top cal_seq_chk #(
  .SUB_W(SUB_W), .FINE_W(LSB_W + CAL_W), .ERR_W(ERR_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .meas_sel(meas_sel), .phase_b(phase_b), .sub_code(sub_code),
  .fine_code(fine_code), .dummy_err(dummy_err)
);

// File: tb/tb_cal_seq_top.sv
module tb_cal_seq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] settle_cycles = '0;
  logic cmp_async;
  logic busy, done, phase_b;
  logic [2:0] meas_sel;
  logic [5:0] sub_code;
  logic [10:0] fine_code;
  logic [2:0] rd_idx = '0;
  logic signed [19:0] rd_err;

  always #5 clk = ~clk;

  cal_seq_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .cmp_async(cmp_async), .busy(busy), .done(done), .meas_sel(meas_sel),
    .phase_b(phase_b), .sub_code(sub_code), .fine_code(fine_code),
    .rd_idx(rd_idx), .rd_err(rd_err)
  );

  int checks = 0;
  int fails  = 0;
  int tA [7];
  int tB [7];
  int lat = 0;
  int exp_hold = 0;
  int hold_bad = 0;
  int fine_bad = 0;
  int done_cnt = 0;
  int exp_q [$];
  int seq_log [$];
  int last_slot = -1;

  // comparator model: high while the code is at or below the target, delayed by lat cycles
  logic cmp_now;
  logic [7:0] hist = '0;
  always_comb begin
    if (meas_sel == 3'd0) cmp_now = (int'(sub_code) <= (phase_b ? tB[0] : tA[0]));
    else cmp_now = (int'(fine_code) <= (phase_b ? tB[meas_sel] : tA[meas_sel]));
  end
  always @(posedge clk) hist <= {hist[6:0], cmp_now};
  always_comb cmp_async = (lat == 0) ? cmp_now : hist[lat-1];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle observation of codes and slot order
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (meas_sel != 3'd0 && int'(sub_code) != exp_hold) hold_bad++;
      if (meas_sel == 3'd0 && fine_code != 11'h7FF) fine_bad++;
      if (int'({meas_sel, phase_b}) != last_slot) begin
        last_slot = int'({meas_sel, phase_b});
        seq_log.push_back(last_slot);
      end
    end
  end

  // scoreboard monitor: on done, read every error and compare with queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
        chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
        for (int i = 0; i < 7; i++) begin
          int e;
          rd_idx = 3'(i);
          #1;
          e = exp_q.pop_front();
          chk(int'(rd_err) == e, (i == 0) ? "R5/R8 dummy error" : "R6/R8 msb error", int'(rd_err), e);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
      end
    end
  end

  task automatic run_cal(int settle, int l, bit poke);
    int s, sum, e0, d0;
    settle_cycles = 4'(settle);
    lat = l;
    s  = tA[0] + tB[0] - 64;
    e0 = -(s >>> 1);
    exp_q.push_back(e0);
    exp_hold = (32 - e0) & 63;
    sum = 0;
    for (int k = 1; k < 7; k++) begin
      int ek;
      ek = sum - (tA[k] - tB[k]);
      exp_q.push_back(ek);
      sum += ek;
    end
    hold_bad = 0; fine_bad = 0; last_slot = -1;
    seq_log.delete();
    d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;               // R10: must be ignored mid-run
      @(negedge clk); start = 1'b0;
    end
    wait (exp_q.size() == 0);
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10/R9 single completion", done_cnt - d0, 1);
    chk(busy == 1'b0, "R10 no restart", int'(busy), 0);
    chk(hold_bad == 0, "R7 sub hold code", hold_bad, 0);
    chk(fine_bad == 0, "R7 fine all ones", fine_bad, 0);
    chk(sub_code == 6'd0 && fine_code == 11'd0, "R11 idle codes", int'(sub_code) + int'(fine_code), 0);
    begin
      bit ok;
      ok = (seq_log.size() == 14);
      for (int j = 0; j < 14 && ok; j++) if (seq_log[j] != j) ok = 1'b0;
      chk(ok, "R2 visit and phase order", seq_log.size(), 14);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) begin tA[i] = 0; tB[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 flags", int'(busy) + int'(done), 0);
    chk(sub_code == 0 && fine_code == 0, "R1 codes", int'(sub_code) + int'(fine_code), 0);
    for (int i = 0; i < 7; i++) begin
      rd_idx = 3'(i); #1;
      chk(rd_err == 0, "R1 stored error", int'(rd_err), 0);
    end

    // run 1: no settle, mid-range targets (R3, R5, R6)
    tA = '{40, 1100, 980, 1500, 700, 1024, 1300};
    tB = '{30, 1000, 1010, 1400, 900, 1024, 1000};
    run_cal(0, 0, 1'b0);

    // run 2: extreme codes, comparator delayed by 5 with settle 5 (R3, R4)
    tA = '{0, 2047, 0, 2047, 0, 1, 2046};
    tB = '{0, 0, 2047, 0, 2047, 2047, 0};
    run_cal(5, 5, 1'b0);

    // run 3: odd dummy sum rounding, settle 2, start pulsed mid-run (R5, R4, R10)
    tA = '{63, 5, 2000, 17, 1023, 1200, 3};
    tB = '{0, 6, 1999, 40, 1022, 800, 2040};
    run_cal(2, 2, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule